// File: doc/BRIEF.md
# Four-Channel Sample Serializer with Frame Marker

This block takes parallel sample words from several converter channels and shifts each one out as a serial stream. All channels are sent in the same bit slots. Everything runs on one fast clock. A bit-enable input decides when the stream moves forward by one bit slot, so the bit rate is set by how often `bit_en` is asserted, not by a second clock. Next to the data lanes the block drives a frame marker and a strobe that shows when a new bit slot is presented.

Each channel owns two output lanes. In split mode the 12-bit word is divided into an upper half and a lower half. The halves go out in parallel, so a frame takes 6 bit slots. In single-lane mode all 12 bits go out on the first lane, a frame takes 12 slots and the second lane stays low. Runtime inputs select the bit order (most or least significant first) and the output coding. Coding is either offset binary, which passes the input word through unchanged, or two's complement, which inverts the top bit.

A sample strobe places new words in a holding register at any time. The serializer takes them from that register only when a frame starts, and it fixes the lane mode and bit order at the same moment. The coding input is also sampled at the frame start.

Top module: `adc_lane_serializer`

## Requirements
- R1: After reset, and until the first cycle with `bit_en` high, every bit of `ser_data`, `frame_out` and `bit_strobe` is 0, even if samples are strobed in meanwhile.
- R2: `bit_strobe` is 1 in the cycle after each cycle with `bit_en` high, and 0 in the cycle after each cycle with `bit_en` low.
- R3: A cycle with `bit_en` low leaves the bit slot unchanged, so `ser_data` and `frame_out` keep their values.
- R4: In split mode (`cfg_two_lane`=1) with MSB-first order (`cfg_lsb_first`=0), frame slot k (k=0..5) drives bit 11-k of channel c's word on `ser_data[2c]` and bit 5-k on `ser_data[2c+1]`.
- R5: With `cfg_lsb_first`=1, slot k drives bit 6+k on `ser_data[2c]` and bit k on `ser_data[2c+1]` in split mode, and bit k on `ser_data[2c]` in single-lane mode.
- R6: In single-lane mode (`cfg_two_lane`=0) a frame lasts 12 slots. Slot k drives bit 11-k on `ser_data[2c]` in MSB-first order, and `ser_data[2c+1]` stays 0.
- R7: With `cfg_twos_comp`=1 the serialized word is the held sample with bit 11 inverted. With 0 it is the held sample unchanged.
- R8: `frame_out` is 1 for the first half of each frame's slots (3 of 6, or 6 of 12) and 0 for the second half.
- R9: A sample strobe in the middle of a frame does not change the rest of that frame. The new words are sent from the next frame start onward.
- R10: Changes of lane mode, bit order or coding in the middle of a frame take effect at the next frame start.
- R11: The channels are serialized at the same time and independently. Channel c takes bits `[12c+11:12c]` of `smp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Advances the serializer by one bit slot per asserted cycle |
| smp_valid | input | 1 | Writes `smp_data` into the holding register |
| smp_data | input | 48 | Four 12-bit samples, channel c at bits 12c+11:12c |
| cfg_two_lane | input | 1 | 1: split the word over two lanes; 0: single lane |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_twos_comp | input | 1 | 1: two's complement output coding |
| ser_data | output | 8 | Serial lanes, channel c on bits 2c (upper or only) and 2c+1 (lower) |
| frame_out | output | 1 | Frame marker, high in the first half of each frame |
| bit_strobe | output | 1 | High for one cycle when a new bit slot is presented |

## Verification
The slot counter, the strobe and the frame words are all registered. The lanes and `frame_out` are combinational decodes of those registers. As a result, the slot selected by a cycle with `bit_en` high, its lane bits, its frame level and the `bit_strobe` pulse all appear together one clock after that cycle. Inputs are driven on the falling edge, and every expectation is sampled on the following falling edge, half a period after the rising edge that produced it. Mid-frame sample strobes and configuration changes are applied during a pause in `bit_en`. The pause cycles themselves are checked for frozen lanes. The frame that follows is checked against the new words and settings.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    typedef enum logic {
        LANE_MODE_ONE = 1'b0,
        LANE_MODE_TWO = 1'b1
    } lane_mode_e;

    typedef struct packed {
        lane_mode_e mode;
        logic       lsb_first;
    } lane_cfg_t;

    // Number of bit slots in one frame for a given word width and lane mode
    function automatic int unsigned frame_slots(lane_mode_e m, int unsigned w);
        return (m == LANE_MODE_TWO) ? w / 2 : w;
    endfunction

    // Word bit carried by a lane in a given slot.
    // upper=1 selects the first lane of a channel, upper=0 the second.
    function automatic int unsigned lane_bit_index(lane_mode_e m, logic lsb,
                                                   logic upper, int unsigned w,
                                                   int unsigned slot);
        int unsigned base;
        int unsigned span;
        if (m == LANE_MODE_TWO) begin
            span = w / 2;
            base = upper ? w / 2 : 0;
        end else begin
            span = w;
            base = 0;
        end
        return lsb ? base + slot : base + span - 1 - slot;
    endfunction

endpackage

// File: rtl/adc_ser_sample_stage.sv
module adc_ser_sample_stage
    import adc_ser_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       load,
    input  logic                       twos_comp,
    output logic [NUM_CH*SAMPLE_W-1:0] frame_word
);
    localparam int FLAT_W = NUM_CH * SAMPLE_W;

    logic [FLAT_W-1:0] hold_q;
    logic [FLAT_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else if (smp_valid) begin
            hold_q <= smp_data;
        end
    end

    // Coding step: inverting the top bit maps offset binary to two's complement
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SAMPLE_W-1:0] coded;
        always_comb begin
            coded = hold_q[c*SAMPLE_W +: SAMPLE_W];
            coded[SAMPLE_W-1] = coded[SAMPLE_W-1] ^ twos_comp;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q[c*SAMPLE_W +: SAMPLE_W] <= '0;
            end else if (load) begin
                word_q[c*SAMPLE_W +: SAMPLE_W] <= coded;
            end
        end
    end

    assign frame_word = word_q;

    // R9: the serialized words change only when a frame starts
    p_word_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(word_q));

endmodule

// File: rtl/adc_ser_slot_timer.sv
module adc_ser_slot_timer
    import adc_ser_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bit_en,
    input  lane_cfg_t                   cfg_in,
    output logic                        load,
    output logic                        running,
    output logic [$clog2(SAMPLE_W)-1:0] slot,
    output lane_cfg_t                   cfg_act,
    output logic                        frame_out,
    output logic                        bit_strobe
);
    localparam int SLOT_W = $clog2(SAMPLE_W);

    logic [SLOT_W-1:0] slot_q;
    logic              run_q;
    logic              strobe_q;
    lane_cfg_t         cfg_q;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] half_slots;

    always_comb begin
        last_slot  = SLOT_W'(frame_slots(cfg_q.mode, SAMPLE_W) - 1);
        half_slots = SLOT_W'(frame_slots(cfg_q.mode, SAMPLE_W) / 2);
    end

    // A frame starts on the first enabled slot after reset or after the last slot
    assign load = bit_en && (!run_q || slot_q == last_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= '0;
            run_q    <= 1'b0;
            strobe_q <= 1'b0;
            cfg_q    <= '0;
        end else begin
            strobe_q <= bit_en;
            if (load) begin
                slot_q <= '0;
                run_q  <= 1'b1;
                cfg_q  <= cfg_in;
            end else if (bit_en) begin
                slot_q <= slot_q + 1'b1;
            end
        end
    end

    assign running    = run_q;
    assign slot       = slot_q;
    assign cfg_act    = cfg_q;
    assign bit_strobe = strobe_q;
    assign frame_out  = run_q && (slot_q < half_slots);

    // R3: without a bit enable the slot position is frozen
    p_slot_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(slot_q) && $stable(run_q)));

    // R8: the slot never runs past the last slot of the active frame length
    p_slot_range_r8: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (slot_q <= last_slot));

    // R8: each frame opens with the marker high
    p_frame_open_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> frame_out);

    // R10: lane mode and order settle only at a frame start
    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_q));

endmodule

// File: rtl/adc_ser_lane_mux.sv
module adc_ser_lane_mux
    import adc_ser_pkg::*;
#(
    parameter int SAMPLE_W = 12
) (
    input  logic [SAMPLE_W-1:0]         word,
    input  logic [$clog2(SAMPLE_W)-1:0] slot,
    input  lane_cfg_t                   cfg,
    input  logic                        running,
    output logic                        lane_hi,
    output logic                        lane_lo
);
    localparam int IDX_W = $clog2(SAMPLE_W);

    logic [IDX_W-1:0] idx_hi;
    logic [IDX_W-1:0] idx_lo;

    always_comb begin
        idx_hi = IDX_W'(lane_bit_index(cfg.mode, cfg.lsb_first, 1'b1,
                                       SAMPLE_W, int'(slot)));
        idx_lo = IDX_W'(lane_bit_index(cfg.mode, cfg.lsb_first, 1'b0,
                                       SAMPLE_W, int'(slot)));
        lane_hi = 1'b0;
        lane_lo = 1'b0;
        if (running) begin
            lane_hi = word[idx_hi];
            if (cfg.mode == LANE_MODE_TWO) begin
                lane_lo = word[idx_lo];
            end
        end
    end

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
    import adc_ser_pkg::*;
#(
    parameter int NUM_CH   = 4,
    parameter int SAMPLE_W = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       bit_en,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       cfg_two_lane,
    input  logic                       cfg_lsb_first,
    input  logic                       cfg_twos_comp,
    output logic [NUM_CH*2-1:0]        ser_data,
    output logic                       frame_out,
    output logic                       bit_strobe
);
    localparam int SLOT_W = $clog2(SAMPLE_W);
    localparam int FLAT_W = NUM_CH * SAMPLE_W;

    lane_cfg_t         cfg_live;
    lane_cfg_t         cfg_act;
    logic              load;
    logic              running;
    logic [SLOT_W-1:0] slot;
    logic [FLAT_W-1:0] frame_word;
    logic [NUM_CH-1:0] lane_hi;
    logic [NUM_CH-1:0] lane_lo;

    always_comb begin
        cfg_live.mode      = cfg_two_lane ? LANE_MODE_TWO : LANE_MODE_ONE;
        cfg_live.lsb_first = cfg_lsb_first;
    end

    adc_ser_slot_timer #(
        .SAMPLE_W (SAMPLE_W)
    ) timer_i (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .cfg_in     (cfg_live),
        .load       (load),
        .running    (running),
        .slot       (slot),
        .cfg_act    (cfg_act),
        .frame_out  (frame_out),
        .bit_strobe (bit_strobe)
    );

    adc_ser_sample_stage #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W)
    ) stage_i (
        .clk        (clk),
        .rst        (rst),
        .smp_valid  (smp_valid),
        .smp_data   (smp_data),
        .load       (load),
        .twos_comp  (cfg_twos_comp),
        .frame_word (frame_word)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        adc_ser_lane_mux #(
            .SAMPLE_W (SAMPLE_W)
        ) mux_i (
            .word    (frame_word[c*SAMPLE_W +: SAMPLE_W]),
            .slot    (slot),
            .cfg     (cfg_act),
            .running (running),
            .lane_hi (lane_hi[c]),
            .lane_lo (lane_lo[c])
        );

        assign ser_data[2*c]   = lane_hi[c];
        assign ser_data[2*c+1] = lane_lo[c];

        // R6: the second lane of a channel is silent in single-lane frames
        p_lane_lo_quiet_r6: assert property (@(posedge clk) disable iff (rst)
            (running && cfg_act.mode == LANE_MODE_ONE) |-> !ser_data[2*c+1]);
    end

    // R1: before the first frame starts, the lanes and the marker stay low
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !running |-> (ser_data == '0 && !frame_out));

endmodule

// File: tb/adc_lane_serializer_tb.sv
`timescale 1ns/1ps
module adc_lane_serializer_tb_top;
    localparam int NCH = 4;
    localparam int W   = 12;

    typedef struct packed {
        logic [NCH*W-1:0] smp;
        logic             two;
        logic             lsb;
        logic             twos;
        logic [NCH*W-1:0] coded;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VECS [NVEC] = '{
        '{48'h800_7FF_000_FFF, 1'b1, 1'b0, 1'b0, 48'h800_7FF_000_FFF},
        '{48'hA5C_123_F0F_3C6, 1'b1, 1'b1, 1'b1, 48'h25C_923_70F_BC6},
        '{48'h5A3_C81_001_ABC, 1'b0, 1'b0, 1'b0, 48'h5A3_C81_001_ABC},
        '{48'h0F0_E1D_765_8A9, 1'b0, 1'b1, 1'b1, 48'h8F0_61D_F65_0A9},
        '{48'h6B2_194_D3E_47A, 1'b1, 1'b0, 1'b1, 48'hEB2_994_53E_C7A},
        '{48'h333_CCC_555_AAA, 1'b0, 1'b0, 1'b1, 48'hB33_4CC_D55_2AA}
    };

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             bit_en = 1'b0;
    logic             smp_valid = 1'b0;
    logic [NCH*W-1:0] smp_data = '0;
    logic             cfg_two_lane = 1'b0;
    logic             cfg_lsb_first = 1'b0;
    logic             cfg_twos_comp = 1'b0;
    logic [NCH*2-1:0] ser_data;
    logic             frame_out;
    logic             bit_strobe;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    adc_lane_serializer #(.NUM_CH(NCH), .SAMPLE_W(W)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .bit_en        (bit_en),
        .smp_valid     (smp_valid),
        .smp_data      (smp_data),
        .cfg_two_lane  (cfg_two_lane),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_twos_comp (cfg_twos_comp),
        .ser_data      (ser_data),
        .frame_out     (frame_out),
        .bit_strobe    (bit_strobe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Lane model from R4, R5, R6, R11
    function automatic logic [NCH*2-1:0] exp_lanes(logic [NCH*W-1:0] coded,
                                                   logic two, logic lsb, int k);
        logic [NCH*2-1:0] r;
        r = '0;
        for (int c = 0; c < NCH; c++) begin
            logic [W-1:0] w;
            w = coded[c*W +: W];
            if (two) begin
                r[2*c]   = lsb ? w[6+k] : w[11-k];
                r[2*c+1] = lsb ? w[k]   : w[5-k];
            end else begin
                r[2*c]   = lsb ? w[k] : w[11-k];
                r[2*c+1] = 1'b0;
            end
        end
        return r;
    endfunction

    function automatic logic [NCH*W-1:0] code_word(logic [NCH*W-1:0] s, logic twos);
        logic [NCH*W-1:0] r;
        r = s;
        for (int c = 0; c < NCH; c++) r[c*W + W-1] = s[c*W + W-1] ^ twos;
        return r;
    endfunction

    task automatic load(input logic [NCH*W-1:0] s, input logic two, input logic lsb,
                        input logic twos);
        bit_en        = 1'b0;
        smp_valid     = 1'b1;
        smp_data      = s;
        cfg_two_lane  = two;
        cfg_lsb_first = lsb;
        cfg_twos_comp = twos;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Plays one frame; optional pause after slot pause_at with a mid-frame update
    task automatic play(input logic [NCH*W-1:0] coded, input logic two, input logic lsb,
                        input int pause_at, input logic inject,
                        input logic [NCH*W-1:0] inj_smp, input logic inj_two,
                        input logic inj_lsb, input logic inj_twos);
        int nslot;
        nslot  = two ? W/2 : W;
        bit_en = 1'b1;
        for (int k = 0; k < nslot; k++) begin
            @(negedge clk);
            check("R4 R5 R6 R7 R11 lanes", 32'(ser_data), 32'(exp_lanes(coded, two, lsb, k)));
            check("R8 frame", 32'(frame_out), 32'(k < nslot/2));
            check("R2 strobe", 32'(bit_strobe), 32'd1);
            if (k == pause_at) begin
                bit_en = 1'b0;
                if (inject) begin
                    smp_valid     = 1'b1;
                    smp_data      = inj_smp;
                    cfg_two_lane  = inj_two;
                    cfg_lsb_first = inj_lsb;
                    cfg_twos_comp = inj_twos;
                end
                for (int p = 0; p < 2; p++) begin
                    @(negedge clk);
                    smp_valid = 1'b0;
                    check("R3 R9 R10 paused lanes", 32'(ser_data),
                          32'(exp_lanes(coded, two, lsb, k)));
                    check("R3 paused frame", 32'(frame_out), 32'(k < nslot/2));
                    check("R2 no strobe", 32'(bit_strobe), 32'd0);
                end
                bit_en = 1'b1;
            end
        end
        bit_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1 reset lanes", 32'(ser_data), 32'd0);
        check("R1 reset frame", 32'(frame_out), 32'd0);
        check("R1 reset strobe", 32'(bit_strobe), 32'd0);
        // R1: a strobed sample alone does not start output
        load(48'hFFF_FFF_FFF_FFF, 1'b1, 1'b0, 1'b0);
        repeat (2) @(negedge clk);
        check("R1 idle lanes", 32'(ser_data), 32'd0);
        check("R1 idle frame", 32'(frame_out), 32'd0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            load(VECS[i].smp, VECS[i].two, VECS[i].lsb, VECS[i].twos);
            check("R2 idle strobe", 32'(bit_strobe), 32'd0);
            play(VECS[i].coded, VECS[i].two, VECS[i].lsb, -1, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        end

        // R9 R10: mid-frame sample and config changes wait for the next frame
        load(48'h9C4_2E7_B18_06D, 1'b1, 1'b0, 1'b0);
        play(48'h9C4_2E7_B18_06D, 1'b1, 1'b0, 2, 1'b1,
             48'h47E_D02_3A9_F51, 1'b0, 1'b1, 1'b1);
        play(code_word(48'h47E_D02_3A9_F51, 1'b1), 1'b0, 1'b1, -1, 1'b0,
             '0, 1'b0, 1'b0, 1'b0);

        // R9 R10: single-lane frame paused late, switching back to split MSB-first
        play(code_word(48'h47E_D02_3A9_F51, 1'b1), 1'b0, 1'b1, 8, 1'b1,
             48'h1B6_E49_7C2_A03, 1'b1, 1'b0, 1'b0);
        play(48'h1B6_E49_7C2_A03, 1'b1, 1'b0, -1, 1'b0, '0, 1'b0, 1'b0, 1'b0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule